// File: doc/BRIEF.md
# Masked-Write GPIO Register Bank

This block is a per-pin GPIO control register file sitting on a simple register bus made of an address, write data, a write strobe and combinational read data. It holds direction, output level, input inversion, output inversion, open-drain enable and two pin-type selections for every pin. From these it drives each pad's output value and output enable, and it returns a cleaned-up input value for each pin.

Most banks use a masked-write word format. The upper half of every 32-bit write carries one write enable per control bit in the lower half. Software can therefore change one pin, or any chosen set of pins, in a single write without first reading the register, and two agents updating different pins never overwrite each other. One pin-type bank is a plain 32-bit read/write word with no mask. A read-only bank returns the synchronised and inversion-corrected pad levels, packed 32 pins per word.

Byte address = bank code × 256 + word index × 4. The bank code sits in address bits 11:8 and the word index in bits 7:2. The bank codes are: 0 direction, 1 output level, 2 input inversion, 3 output inversion, 4 open-drain, 5 masked pin-type, 6 plain pin-type, 7 input sample.

Top module: `gpio_mask_bank`

## Requirements
- R1: After reset every register reads zero, and pad_oe, pad_out and pin_in are all zero. Every pin therefore comes up as an input with no inversion.
- R2: A write to a masked bank (codes 0 to 5) changes control bit k (0..15) only when write-data bit 16+k of the same write is 1. Control bits whose enable is 0 keep their value.
- R3: In a masked bank, pin n sits in word n/16 at bit n%16. The word's byte address is bank code × 256 + (n/16) × 4.
- R4: Reading a masked bank returns the control bits in bits 15:0 and zeros in bits 31:16.
- R5: The plain pin-type bank (code 6) stores all 32 bits of every write. Pin n sits in word n/32 at bit n%32, and a read returns the stored word.
- R6: With open-drain off, pad_oe[n] equals the direction bit (1 = output, 0 = input) and pad_out[n] equals output level XOR output inversion.
- R7: With open-drain on, pad_out[n] is 0 and pad_oe[n] is 1 only when the direction bit is 1 and the value (output level XOR output inversion) is 0. An open-drain pin is never driven high.
- R8: pin_in[n] equals pad_in[n] passed through SYNC_STAGES flip-flops (default 2), XOR the input-inversion bit. A pad change therefore shows two clock edges later.
- R9: The input-sample bank (code 7) is read-only and returns pin_in, with pin n in word n/32 at bit n%32. Writes to this bank change nothing.
- R10: Reads of unused bank codes (8 to 15), and of word indexes beyond a bank's size, return zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address: bank code in bits 11:8, word index in bits 7:2 |
| bus_wdata | input | 32 | Write data; in masked banks bits 31:16 are per-bit enables |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | NUM_PINS | Raw pad levels, asynchronous |
| pad_out | output | NUM_PINS | Value driven on each pad |
| pad_oe | output | NUM_PINS | Pad drive enable, 1 = driven |
| pin_in | output | NUM_PINS | Synchronised and inversion-corrected input values |

## Verification
The hardest case to reach from the ports is open-drain release. It needs direction, open-drain, output level and output inversion all set on one pin, and then one of the last two must be flipped by a masked write whose enables touch only that bit. The stimulus builds this state one bit at a time on pin 0. It confirms that the pad is driven low, then clears only the inversion bit and checks that the drive enable drops while neighbouring bits keep their values. Input inversion is reached the same way: a pad is raised, the result is observed across both synchroniser edges, and only then is the inversion bit set, with the result read back through the input-sample bank.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
   localparam int CTRL_BITS = 16;
   localparam int WORD_W    = 6;
   localparam int BANK_W    = 4;
   localparam int ADDR_W    = BANK_W + WORD_W + 2;
   localparam int N_MASKED  = 6;

   typedef enum logic [BANK_W-1:0] {
      BK_DIR   = 4'd0,
      BK_LEVEL = 4'd1,
      BK_IINV  = 4'd2,
      BK_OINV  = 4'd3,
      BK_OPEN  = 4'd4,
      BK_MODE  = 4'd5,
      BK_SEL   = 4'd6,
      BK_SAMP  = 4'd7
   } bank_e;
endpackage

// File: rtl/gpb_masked_bank.sv
module gpb_masked_bank #(
   parameter int WORDS = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [gpb_pkg::WORD_W-1:0]       wr_word,
   input  logic [31:0]                      wr_data,
   output logic [WORDS*gpb_pkg::CTRL_BITS-1:0] bits
);
   localparam int CB = gpb_pkg::CTRL_BITS;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [CB-1:0] q;
      logic [CB-1:0] en;
      assign en = wr_data[2*CB-1:CB];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && wr_word == gpb_pkg::WORD_W'(w))
            q <= (q & ~en) | (wr_data[CB-1:0] & en);
      end
      assign bits[w*CB +: CB] = q;
   end
endmodule

// File: rtl/gpb_plain_bank.sv
module gpb_plain_bank #(
   parameter int WORDS = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [gpb_pkg::WORD_W-1:0] wr_word,
   input  logic [31:0]                wr_data,
   output logic [WORDS*32-1:0]        bits
);
   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [31:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && wr_word == gpb_pkg::WORD_W'(w))
            q <= wr_data;
      end
      assign bits[w*32 +: 32] = q;
   end
endmodule

// File: rtl/gpb_sync.sv
module gpb_sync #(
   parameter int WIDTH  = 128,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         chain[0] <= '0;
      else
         chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chain[s] <= '0;
         else
            chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank #(
   parameter int NUM_PINS    = 128,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [gpb_pkg::ADDR_W-1:0] bus_addr,
   input  logic [31:0]                bus_wdata,
   input  logic                       bus_we,
   output logic [31:0]                bus_rdata,
   input  logic [NUM_PINS-1:0]        pad_in,
   output logic [NUM_PINS-1:0]        pad_out,
   output logic [NUM_PINS-1:0]        pad_oe,
   output logic [NUM_PINS-1:0]        pin_in
);
   import gpb_pkg::*;

   localparam int MWORDS = NUM_PINS / CTRL_BITS;
   localparam int PWORDS = NUM_PINS / 32;

   if (NUM_PINS < 32 || NUM_PINS % 32 != 0) begin : g_bad_pins
      $error("NUM_PINS must be a non-zero multiple of 32");
   end
   if (MWORDS > (1 << WORD_W)) begin : g_bad_span
      $error("NUM_PINS exceeds the word index range of one bank");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   logic [BANK_W-1:0] bank;
   logic [WORD_W-1:0] word;
   assign bank = bus_addr[ADDR_W-1 -: BANK_W];
   assign word = bus_addr[WORD_W+1:2];

   logic [NUM_PINS-1:0] mbits [N_MASKED];

   for (genvar b = 0; b < N_MASKED; b++) begin : g_mbank
      gpb_masked_bank #(.WORDS(MWORDS)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (bus_we && bank == BANK_W'(b)),
         .wr_word (word),
         .wr_data (bus_wdata),
         .bits    (mbits[b])
      );
   end

   logic [NUM_PINS-1:0] oe_q, lvl_q, iinv_q, oinv_q, od_q, sel_q;
   assign oe_q   = mbits[BK_DIR];
   assign lvl_q  = mbits[BK_LEVEL];
   assign iinv_q = mbits[BK_IINV];
   assign oinv_q = mbits[BK_OINV];
   assign od_q   = mbits[BK_OPEN];

   gpb_plain_bank #(.WORDS(PWORDS)) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_we && bank == BK_SEL),
      .wr_word (word),
      .wr_data (bus_wdata),
      .bits    (sel_q)
   );

   logic [NUM_PINS-1:0] pad_sync;
   gpb_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pad_sync)
   );

   logic [NUM_PINS-1:0] value;
   assign value   = lvl_q ^ oinv_q;
   assign pad_out = value & ~od_q;
   assign pad_oe  = oe_q & ~(od_q & value);
   assign pin_in  = pad_sync ^ iinv_q;

   always_comb begin
      bus_rdata = '0;
      if (bank < BANK_W'(N_MASKED)) begin
         for (int w = 0; w < MWORDS; w++)
            if (word == WORD_W'(w))
               bus_rdata = {16'h0, mbits[bank[2:0]][w*CTRL_BITS +: CTRL_BITS]};
      end else if (bank == BK_SEL) begin
         for (int w = 0; w < PWORDS; w++)
            if (word == WORD_W'(w))
               bus_rdata = sel_q[w*32 +: 32];
      end else if (bank == BK_SAMP) begin
         for (int w = 0; w < PWORDS; w++)
            if (word == WORD_W'(w))
               bus_rdata = pin_in[w*32 +: 32];
      end
   end
endmodule

// File: rtl/gpio_mask_bank_chk.sv
module gpio_mask_bank_chk #(
   parameter int NUM_PINS = 128
) (
   input logic                clk,
   input logic                rst_n,
   input logic [11:0]         bus_addr,
   input logic [31:0]         bus_wdata,
   input logic                bus_we,
   input logic [31:0]         bus_rdata,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] od_q,
   input logic [31:0]         sel_word0
);
   // R2: enables all clear on direction word 0 leave the drive enables alone
   assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr[11:2] == 10'h000 && bus_wdata[31:16] == 16'h0)
      |=> $stable(pad_oe));

   // R4: masked banks read back with an empty upper half
   assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[11:8] <= 4'd5) |-> (bus_rdata[31:16] == 16'h0));

   // R5: plain word 0 takes the whole written word
   assert_plain_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr[11:2] == {4'd6, 6'd0}) |=> (sel_word0 == $past(bus_wdata)));

   // R7: an open-drain pin is never driven high
   assert_od_no_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (od_q & pad_oe & pad_out) == '0);

   // R9: writes to the sample bank leave the pads untouched
   assert_sample_ro_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr[11:8] == 4'd7) |=> ($stable(pad_oe) && $stable(pad_out)));

   // R10: writes to unused banks change nothing visible
   assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr[11:8] > 4'd7)
      |=> ($stable(pad_oe) && $stable(pad_out) && $stable(sel_word0)));
endmodule

bind gpio_mask_bank gpio_mask_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_we    (bus_we),
   .bus_rdata (bus_rdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .od_q      (od_q),
   .sel_word0 (sel_q[31:0])
);

// File: tb/gpio_mask_bank_test.sv
module gpio_mask_bank_test;
   localparam int NP = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic          bus_we = 1'b0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out, pad_oe, pin_in;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   gpio_mask_bank #(.NUM_PINS(NP), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pin_in(pin_in)
   );

   typedef struct packed {
      logic [11:0] waddr;
      logic [31:0] wdata;
      logic [11:0] raddr;
      logic [31:0] expect_rd;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t TBL [NV] = '{
      '{12'h000, 32'hFFFF_00A5, 12'h000, 32'h0000_00A5}, // R2 R4 full enable
      '{12'h000, 32'h0003_FFFF, 12'h000, 32'h0000_00A7}, // R2 partial enable
      '{12'h104, 32'h8000_8000, 12'h104, 32'h0000_8000}, // R3 pin 31
      '{12'h11C, 32'h0001_0001, 12'h11C, 32'h0000_0001}, // R3 pin 112
      '{12'h50C, 32'hFFFF_1234, 12'h50C, 32'h0000_1234}, // R4 masked type bank
      '{12'h608, 32'hDEAD_BEEF, 12'h608, 32'hDEAD_BEEF}, // R5 plain word 2
      '{12'h700, 32'hFFFF_FFFF, 12'h700, 32'h0000_0000}, // R9 sample ignores write
      '{12'h900, 32'hFFFF_FFFF, 12'h900, 32'h0000_0000}, // R10 unused bank
      '{12'h020, 32'hFFFF_FFFF, 12'h000, 32'h0000_00A7}, // R10 word past end
      '{12'h200, 32'h0000_FFFF, 12'h200, 32'h0000_0000}  // R2 no enables
   };

   task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      do_reset();
      // R1 reset state
      check32("R1 pad_oe", pad_oe[31:0] | pad_oe[127:96], 32'h0);
      check32("R1 pad_out", pad_out[31:0] | pad_out[127:96], 32'h0);
      bus_read(12'h000, rd); check32("R1 dir read", rd, 32'h0);
      bus_read(12'h600, rd); check32("R1 plain read", rd, 32'h0);

      for (int i = 0; i < NV; i++) begin
         bus_write(TBL[i].waddr, TBL[i].wdata);
         bus_read(TBL[i].raddr, rd);
         check32($sformatf("table entry %0d (R2/R3/R4/R5/R9/R10)", i), rd, TBL[i].expect_rd);
      end
      check32("R3 pad_out pin 31 and 112", {31'h0, pad_out[31]} + {31'h0, pad_out[112]}, 32'd2);
      check32("R6 pad_oe low byte", {24'h0, pad_oe[7:0]}, 32'h0000_00A7);

      do_reset();
      bus_read(12'h608, rd); check32("R1 plain cleared", rd, 32'h0);
      bus_write(12'h000, 32'h0001_0001);
      bus_write(12'h100, 32'h0001_0001);
      check32("R6 push-pull high", {30'h0, pad_oe[0], pad_out[0]}, 32'h3);
      bus_write(12'h300, 32'h0001_0001);
      check32("R6 output inversion", {30'h0, pad_oe[0], pad_out[0]}, 32'h2);
      bus_write(12'h400, 32'h0001_0001);
      check32("R7 open-drain drives low", {30'h0, pad_oe[0], pad_out[0]}, 32'h2);
      bus_write(12'h300, 32'h0001_0000);
      check32("R7 open-drain releases", {30'h0, pad_oe[0], pad_out[0]}, 32'h0);
      bus_read(12'h100, rd); check32("R2 level kept", rd, 32'h0000_0001);

      @(negedge clk);
      pad_in[5] = 1'b1; pad_in[40] = 1'b1;
      @(negedge clk);
      check32("R8 after one edge", {31'h0, pin_in[5]}, 32'h0);
      @(negedge clk);
      check32("R8 after two edges", {31'h0, pin_in[5]}, 32'h1);
      bus_read(12'h704, rd); check32("R9 sample word 1", rd, 32'h0000_0100);
      bus_write(12'h200, 32'h0020_0020);
      check32("R8 input inversion", {31'h0, pin_in[5]}, 32'h0);
      bus_read(12'h700, rd); check32("R9 sample inverted", rd, 32'h0);
      bus_write(12'h704, 32'h0);
      bus_read(12'h704, rd); check32("R9 sample after write", rd, 32'h0000_0100);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule